// File: doc/BRIEF.md
# 24-Pin GPIO Port Register File

This block is the register and pad-control core of a 24-pin general-purpose I/O port. A byte-wide register bus (address, write data, write strobe, read strobe, read data) gives a host access to per-pin configuration. Each configuration class covers 24 pins in three consecutive byte addresses. Pin n sits in byte n/8 of its class, at bit n mod 8. The block turns the stored bits straight into pad controls: output value, output enable, open-drain select, pull-up enable and pull-down enable.

The output latch has no plain write path. A host changes it only by writing ones into a set register or a clear register, so it never needs a read-modify-write to move one pin. Bias and drive mode have no fields of their own. They are decoded together from three bits per pin: direction, type and pull-select. Pad inputs are resynchronized and can be read back through a read-only state register.

Pins 16-19 and pins 20-23 form two blocks that other functions of a larger device can take over. Each block has its own enable input. While a block is disabled its pins read as zero, ignore writes and drive every pad control low.

Top module: `gpx_port24`

## Requirements
- R1: After reset every pin is an input, the type, pull-select and output latch bits are 0, all pad controls are low and the read data is 0.
- R2: Direction bytes sit at 0x60-0x62, type bytes at 0x64-0x66 and pull-select bytes at 0x68-0x6A. Each byte is written at the clock edge where the write strobe is high, and it reads back what was written. Read data is registered: it updates on the edge where the read strobe is high and holds at all other times.
- R3: A direction bit of 1 raises the pin's output enable and a direction bit of 0 lowers it.
- R4: Writing ones to 0x6C-0x6E drives those pins' output latch high. Writing ones to 0x70-0x72 drives it low. Zero bits leave the latch unchanged. The pad output value follows the latch, and both registers read as 0.
- R5: On an output pin, type 0 gives push-pull with no pull. Type 1 raises open-drain, and pull-select 1 then also raises pull-up.
- R6: On an input pin with type 1, pull-select 1 raises pull-up and pull-select 0 raises pull-down. With type 0 neither pull is raised. Pull-up and pull-down are never high together.
- R7: 0x10-0x12 return the pad inputs through a two-flop synchronizer. A read captured at the first edge after an input change returns the old level, and a read two edges later returns the new one. Writes to these addresses change nothing.
- R8: While the low-block enable is 0, pins 16-19 read as 0 in every register, drive all pad controls low and keep their stored bits through writes. The high-block enable governs pins 20-23 the same way.
- R9: A read and a write to the same address in the same cycle return the content from before the write. The written value is returned by the next read.
- R10: Addresses outside the mapped ranges read as 0, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Register byte address |
| bus_wdata | input | 8 | Write data |
| bus_wr | input | 1 | Write strobe, one byte per cycle |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 8 | Registered read data |
| ext_lo_en | input | 1 | Enable for pins 16-19 |
| ext_hi_en | input | 1 | Enable for pins 20-23 |
| pad_in | input | 24 | Asynchronous pad input levels |
| pad_out | output | 24 | Pad output value |
| pad_oe | output | 24 | Pad output enable |
| pad_od | output | 24 | Pad open-drain select |
| pad_pu | output | 24 | Pad pull-up enable |
| pad_pd | output | 24 | Pad pull-down enable |

## Verification
Register read and register write can fall in the same cycle, and so can a pad input change and a state read. The bench raises both strobes to one address in a single cycle. It expects the old byte on that read and the new byte on the next one. It also changes the pad inputs in the same cycle a state read is issued. It expects the previous level from that read and the new level once two edges have passed through the synchronizer.

// File: rtl/gpx_pkg.sv
package gpx_pkg;

  localparam int unsigned LANE_W = 8;
  typedef logic [LANE_W-1:0] lane_t;

  localparam lane_t A_STATE = 8'h10;
  localparam lane_t A_DIR   = 8'h60;
  localparam lane_t A_TYPE  = 8'h64;
  localparam lane_t A_PULL  = 8'h68;
  localparam lane_t A_SET   = 8'h6C;
  localparam lane_t A_CLR   = 8'h70;

  typedef enum logic [2:0] {
    RG_NONE, RG_STATE, RG_DIR, RG_TYPE, RG_PULL, RG_SET, RG_CLR
  } reg_grp_e;

  typedef struct packed {
    logic out;
    logic oe;
    logic od;
    logic pu;
    logic pd;
  } pad_ctl_t;

  function automatic logic in_win(lane_t a, lane_t base, lane_t nb);
    return (a >= base) && (a < base + nb);
  endfunction

  function automatic reg_grp_e grp_of(lane_t a, lane_t nb);
    if (in_win(a, A_STATE, nb)) return RG_STATE;
    if (in_win(a, A_DIR, nb))   return RG_DIR;
    if (in_win(a, A_TYPE, nb))  return RG_TYPE;
    if (in_win(a, A_PULL, nb))  return RG_PULL;
    if (in_win(a, A_SET, nb))   return RG_SET;
    if (in_win(a, A_CLR, nb))   return RG_CLR;
    return RG_NONE;
  endfunction

  function automatic lane_t base_of(reg_grp_e g);
    case (g)
      RG_STATE: return A_STATE;
      RG_DIR:   return A_DIR;
      RG_TYPE:  return A_TYPE;
      RG_PULL:  return A_PULL;
      RG_SET:   return A_SET;
      RG_CLR:   return A_CLR;
      default:  return '0;
    endcase
  endfunction

  // Replace only the bits selected by the valid mask
  function automatic lane_t merge_lane(lane_t old, lane_t wd, lane_t vm);
    return (old & ~vm) | (wd & vm);
  endfunction

  // Latch update from set and clear masks; clear dominates
  function automatic lane_t next_latch(lane_t old, lane_t set_m, lane_t clr_m);
    return (old | set_m) & ~clr_m;
  endfunction

  // Joint decode of direction, type and pull-select into pad controls
  function automatic pad_ctl_t pin_decode(logic dir, logic typ, logic pul,
                                          logic lat, logic en);
    pad_ctl_t c;
    c = '0;
    if (en) begin
      c.out = lat;
      c.oe  = dir;
      c.od  = dir & typ;
      c.pu  = typ & pul;
      c.pd  = ~dir & typ & ~pul;
    end
    return c;
  endfunction

endpackage

// File: rtl/gpx_sync2.sv
module gpx_sync2 #(
  parameter int unsigned W = 24
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] s1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= '0;
      q  <= '0;
    end else begin
      s1 <= d;
      q  <= s1;
    end
  end
endmodule

// File: rtl/gpx_cfg_regs.sv
module gpx_cfg_regs
  import gpx_pkg::*;
#(
  parameter int unsigned NUM_BYTES = 3,
  parameter int unsigned IDX_W     = 2
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          wr_dir,
  input  logic                          wr_typ,
  input  logic                          wr_pul,
  input  logic                          wr_set,
  input  logic                          wr_clr,
  input  logic [IDX_W-1:0]              idx,
  input  lane_t                         wdata,
  input  logic [NUM_BYTES*LANE_W-1:0]   valid,
  output logic [NUM_BYTES*LANE_W-1:0]   dir_q,
  output logic [NUM_BYTES*LANE_W-1:0]   typ_q,
  output logic [NUM_BYTES*LANE_W-1:0]   pul_q,
  output logic [NUM_BYTES*LANE_W-1:0]   lat_q
);
  lane_t dir_r [NUM_BYTES];
  lane_t typ_r [NUM_BYTES];
  lane_t pul_r [NUM_BYTES];
  lane_t lat_r [NUM_BYTES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int b = 0; b < NUM_BYTES; b++) begin
        dir_r[b] <= '0;
        typ_r[b] <= '0;
        pul_r[b] <= '0;
        lat_r[b] <= '0;
      end
    end else begin
      for (int b = 0; b < NUM_BYTES; b++) begin
        if (idx == IDX_W'(b)) begin
          if (wr_dir) dir_r[b] <= merge_lane(dir_r[b], wdata, valid[b*LANE_W +: LANE_W]);
          if (wr_typ) typ_r[b] <= merge_lane(typ_r[b], wdata, valid[b*LANE_W +: LANE_W]);
          if (wr_pul) pul_r[b] <= merge_lane(pul_r[b], wdata, valid[b*LANE_W +: LANE_W]);
          if (wr_set || wr_clr)
            lat_r[b] <= next_latch(lat_r[b],
                          wr_set ? (wdata & valid[b*LANE_W +: LANE_W]) : '0,
                          wr_clr ? (wdata & valid[b*LANE_W +: LANE_W]) : '0);
        end
      end
    end
  end

  for (genvar g = 0; g < NUM_BYTES; g++) begin : g_flat
    assign dir_q[g*LANE_W +: LANE_W] = dir_r[g];
    assign typ_q[g*LANE_W +: LANE_W] = typ_r[g];
    assign pul_q[g*LANE_W +: LANE_W] = pul_r[g];
    assign lat_q[g*LANE_W +: LANE_W] = lat_r[g];
  end
endmodule

// File: rtl/gpx_pad_decode.sv
module gpx_pad_decode
  import gpx_pkg::*;
#(
  parameter int unsigned NUM_PINS = 24
) (
  input  logic [NUM_PINS-1:0] dir_q,
  input  logic [NUM_PINS-1:0] typ_q,
  input  logic [NUM_PINS-1:0] pul_q,
  input  logic [NUM_PINS-1:0] lat_q,
  input  logic [NUM_PINS-1:0] valid,
  output logic [NUM_PINS-1:0] pad_out,
  output logic [NUM_PINS-1:0] pad_oe,
  output logic [NUM_PINS-1:0] pad_od,
  output logic [NUM_PINS-1:0] pad_pu,
  output logic [NUM_PINS-1:0] pad_pd
);
  for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
    pad_ctl_t ctl;
    assign ctl        = pin_decode(dir_q[i], typ_q[i], pul_q[i], lat_q[i], valid[i]);
    assign pad_out[i] = ctl.out;
    assign pad_oe[i]  = ctl.oe;
    assign pad_od[i]  = ctl.od;
    assign pad_pu[i]  = ctl.pu;
    assign pad_pd[i]  = ctl.pd;
  end
endmodule

// File: rtl/gpx_port24.sv
module gpx_port24
  import gpx_pkg::*;
#(
  parameter int unsigned NUM_BYTES = 3,
  parameter int unsigned LO_FIRST  = 16,
  parameter int unsigned HI_FIRST  = 20,
  parameter int unsigned GRP_SZ    = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [7:0]  bus_addr,
  input  logic [7:0]  bus_wdata,
  input  logic        bus_wr,
  input  logic        bus_rd,
  output logic [7:0]  bus_rdata,
  input  logic        ext_lo_en,
  input  logic        ext_hi_en,
  input  logic [23:0] pad_in,
  output logic [23:0] pad_out,
  output logic [23:0] pad_oe,
  output logic [23:0] pad_od,
  output logic [23:0] pad_pu,
  output logic [23:0] pad_pd
);
  localparam int unsigned NUM_PINS = NUM_BYTES * LANE_W;
  localparam int unsigned IDX_W    = (NUM_BYTES > 1) ? $clog2(NUM_BYTES) : 1;
  localparam lane_t       NB8      = lane_t'(NUM_BYTES);

  // Named internal events, also observed by the checker
  reg_grp_e              grp;
  lane_t                 offs;
  logic [IDX_W-1:0]      idx;
  logic                  dir_hit, typ_hit, pul_hit, set_hit, clr_hit;
  logic [NUM_PINS-1:0]   valid;
  logic [NUM_PINS-1:0]   st_sync;
  logic [NUM_PINS-1:0]   dir_q, typ_q, pul_q, out_latch;
  logic [NUM_PINS-1:0]   rd_src;
  lane_t                 rd_mux;

  assign grp  = grp_of(bus_addr, NB8);
  assign offs = bus_addr - base_of(grp);
  assign idx  = offs[IDX_W-1:0];

  assign dir_hit = bus_wr && (grp == RG_DIR);
  assign typ_hit = bus_wr && (grp == RG_TYPE);
  assign pul_hit = bus_wr && (grp == RG_PULL);
  assign set_hit = bus_wr && (grp == RG_SET);
  assign clr_hit = bus_wr && (grp == RG_CLR);

  always_comb begin
    for (int i = 0; i < NUM_PINS; i++) begin
      if (i >= LO_FIRST && i < LO_FIRST + GRP_SZ)      valid[i] = ext_lo_en;
      else if (i >= HI_FIRST && i < HI_FIRST + GRP_SZ) valid[i] = ext_hi_en;
      else                                             valid[i] = 1'b1;
    end
  end

  gpx_sync2 #(.W(NUM_PINS)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (pad_in),
    .q     (st_sync)
  );

  gpx_cfg_regs #(.NUM_BYTES(NUM_BYTES), .IDX_W(IDX_W)) u_regs (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_dir (dir_hit),
    .wr_typ (typ_hit),
    .wr_pul (pul_hit),
    .wr_set (set_hit),
    .wr_clr (clr_hit),
    .idx    (idx),
    .wdata  (bus_wdata),
    .valid  (valid),
    .dir_q  (dir_q),
    .typ_q  (typ_q),
    .pul_q  (pul_q),
    .lat_q  (out_latch)
  );

  gpx_pad_decode #(.NUM_PINS(NUM_PINS)) u_pads (
    .dir_q   (dir_q),
    .typ_q   (typ_q),
    .pul_q   (pul_q),
    .lat_q   (out_latch),
    .valid   (valid),
    .pad_out (pad_out),
    .pad_oe  (pad_oe),
    .pad_od  (pad_od),
    .pad_pu  (pad_pu),
    .pad_pd  (pad_pd)
  );

  // Read path: set/clear and unmapped addresses return zero
  always_comb begin
    case (grp)
      RG_STATE: rd_src = st_sync;
      RG_DIR:   rd_src = dir_q;
      RG_TYPE:  rd_src = typ_q;
      RG_PULL:  rd_src = pul_q;
      default:  rd_src = '0;
    endcase
    rd_mux = '0;
    for (int b = 0; b < NUM_BYTES; b++) begin
      if (idx == IDX_W'(b))
        rd_mux = rd_src[b*LANE_W +: LANE_W] & valid[b*LANE_W +: LANE_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_mux;
  end
endmodule

// File: rtl/gpx_port24_chk.sv
module gpx_port24_chk
  import gpx_pkg::*;
#(
  parameter int unsigned NUM_PINS = 24,
  parameter int unsigned LO_FIRST = 16,
  parameter int unsigned HI_FIRST = 20,
  parameter int unsigned GRP_SZ   = 4
) (
  input logic                clk,
  input logic                rst_n,
  input logic [7:0]          bus_addr,
  input logic [7:0]          bus_wdata,
  input logic                bus_wr,
  input logic                bus_rd,
  input logic [7:0]          bus_rdata,
  input logic                ext_lo_en,
  input logic                ext_hi_en,
  input logic [NUM_PINS-1:0] pad_out,
  input logic [NUM_PINS-1:0] pad_oe,
  input logic [NUM_PINS-1:0] pad_od,
  input logic [NUM_PINS-1:0] pad_pu,
  input logic [NUM_PINS-1:0] pad_pd,
  input logic                set_hit,
  input logic                clr_hit,
  input logic [NUM_PINS-1:0] out_latch
);
  a_r2_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> $stable(bus_rdata));

  a_r4_set_raises: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == A_SET) |=> ((pad_out[7:0] & $past(bus_wdata)) == $past(bus_wdata)));

  a_r4_clr_lowers: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == A_CLR) |=> ((pad_out[7:0] & $past(bus_wdata)) == 8'h00));

  a_r4_latch_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(set_hit || clr_hit) |=> $stable(out_latch));

  a_r5_od_needs_oe: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_od & ~pad_oe) == '0);

  a_r6_no_dual_pull: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_pu & pad_pd) == '0);

  a_r8_lo_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !ext_lo_en |-> ((pad_out[LO_FIRST +: GRP_SZ] | pad_oe[LO_FIRST +: GRP_SZ] |
                     pad_pu[LO_FIRST +: GRP_SZ]  | pad_pd[LO_FIRST +: GRP_SZ]) == '0));

  a_r8_hi_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !ext_hi_en |-> ((pad_out[HI_FIRST +: GRP_SZ] | pad_oe[HI_FIRST +: GRP_SZ] |
                     pad_pu[HI_FIRST +: GRP_SZ]  | pad_pd[HI_FIRST +: GRP_SZ]) == '0));
endmodule

bind gpx_port24 gpx_port24_chk #(
  .NUM_PINS (NUM_PINS),
  .LO_FIRST (LO_FIRST),
  .HI_FIRST (HI_FIRST),
  .GRP_SZ   (GRP_SZ)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .bus_wr    (bus_wr),
  .bus_rd    (bus_rd),
  .bus_rdata (bus_rdata),
  .ext_lo_en (ext_lo_en),
  .ext_hi_en (ext_hi_en),
  .pad_out   (pad_out),
  .pad_oe    (pad_oe),
  .pad_od    (pad_od),
  .pad_pu    (pad_pu),
  .pad_pd    (pad_pd),
  .set_hit   (set_hit),
  .clr_hit   (clr_hit),
  .out_latch (out_latch)
);

// File: tb/gpx_port24_tb.sv
module gpx_port24_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [7:0]  bus_wdata = '0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [7:0]  bus_rdata;
  logic        ext_lo_en = 1'b1;
  logic        ext_hi_en = 1'b1;
  logic [23:0] pad_in = '0;
  logic [23:0] pad_out, pad_oe, pad_od, pad_pu, pad_pd;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  gpx_port24 u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_rdata (bus_rdata),
    .ext_lo_en (ext_lo_en),
    .ext_hi_en (ext_hi_en),
    .pad_in    (pad_in),
    .pad_out   (pad_out),
    .pad_oe    (pad_oe),
    .pad_od    (pad_od),
    .pad_pu    (pad_pu),
    .pad_pd    (pad_pd)
  );

  // Vector: {is_write, addr, data, expected read}
  localparam int NV = 16;
  localparam logic [24:0] VEC [NV] = '{
    {1'b1, 8'h60, 8'hA5, 8'h00}, {1'b0, 8'h60, 8'h00, 8'hA5},
    {1'b1, 8'h62, 8'h0F, 8'h00}, {1'b0, 8'h62, 8'h00, 8'h0F},
    {1'b1, 8'h65, 8'h3C, 8'h00}, {1'b0, 8'h65, 8'h00, 8'h3C},
    {1'b1, 8'h6A, 8'h81, 8'h00}, {1'b0, 8'h6A, 8'h00, 8'h81},
    {1'b1, 8'h6C, 8'hF0, 8'h00}, {1'b0, 8'h6C, 8'h00, 8'h00},
    {1'b1, 8'h10, 8'hFF, 8'h00}, {1'b0, 8'h10, 8'h00, 8'h00},
    {1'b1, 8'h63, 8'hFF, 8'h00}, {1'b0, 8'h63, 8'h00, 8'h00},
    {1'b1, 8'h5F, 8'h77, 8'h00}, {1'b0, 8'h60, 8'h00, 8'hA5}
  };

  function automatic string vec_tag(logic [7:0] a);
    if (a >= 8'h10 && a <= 8'h12) return "R7";
    if (a >= 8'h6C && a <= 8'h72) return "R4";
    if ((a >= 8'h60 && a <= 8'h62) || (a >= 8'h64 && a <= 8'h66) ||
        (a >= 8'h68 && a <= 8'h6A)) return "R2";
    return "R10";
  endfunction

  task automatic check(string tag, logic [23:0] act, logic [23:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // All bus tasks start and end on a falling edge
  task automatic bus_write(logic [7:0] a, logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(string tag, logic [7:0] a, logic [7:0] exp);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    check(tag, {16'h0, bus_rdata}, {16'h0, exp});
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    #(8 * 150000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    do_reset();

    // Table walk over register access (R2, R4, R7, R10)
    for (int k = 0; k < NV; k++) begin
      if (VEC[k][24]) bus_write(VEC[k][23:16], VEC[k][15:8]);
      else            bus_read(vec_tag(VEC[k][23:16]), VEC[k][23:16], VEC[k][7:0]);
    end

    // R1: reset state
    do_reset();
    check("R1 rdata", {16'h0, bus_rdata}, 24'h0);
    check("R1 oe", pad_oe, 24'h0);
    check("R1 out", pad_out, 24'h0);
    check("R1 pulls/od", pad_pu | pad_pd | pad_od, 24'h0);
    bus_read("R1 dir byte", 8'h61, 8'h00);

    // R3: direction drives output enable
    bus_write(8'h60, 8'h01);
    bus_write(8'h61, 8'h80);
    check("R3 oe", pad_oe, 24'h008001);

    // R4: set and clear registers
    bus_write(8'h6C, 8'h03);
    check("R4 set", pad_out, 24'h000003);
    bus_write(8'h70, 8'h01);
    check("R4 clear", pad_out, 24'h000002);
    bus_write(8'h6C, 8'h00);
    check("R4 zero bits", pad_out, 24'h000002);
    bus_write(8'h6E, 8'hFF);
    check("R4 set high byte", pad_out, 24'hFF0002);

    // R8: high block disabled masks and ignores writes
    ext_hi_en = 1'b0; #1;
    check("R8 hi masked out", pad_out, 24'h0F0002);
    @(negedge clk);
    bus_write(8'h72, 8'hFF);
    check("R8 hi clear partial", pad_out, 24'h000002);
    ext_hi_en = 1'b1; #1;
    check("R8 hi kept latch", pad_out, 24'hF00002);
    @(negedge clk);

    // R8: low block disabled
    ext_lo_en = 1'b0;
    bus_write(8'h62, 8'hFF);
    bus_read("R8 lo read masked", 8'h62, 8'hF0);
    check("R8 lo oe", pad_oe, 24'hF08001);
    ext_lo_en = 1'b1;
    bus_read("R8 lo kept dir", 8'h62, 8'hF0);

    // R5: pin 0 is an output
    bus_write(8'h64, 8'h01);
    bus_write(8'h68, 8'h01);
    check("R5 od pu", {pad_od[0], pad_pu[0], pad_pd[0]}, 24'h6);
    bus_write(8'h68, 8'h00);
    check("R5 od no pull", {pad_od[0], pad_pu[0], pad_pd[0]}, 24'h4);
    bus_write(8'h64, 8'h00);
    check("R5 push-pull", {pad_od[0], pad_pu[0], pad_pd[0]}, 24'h0);

    // R6: pin 1 is an input
    bus_write(8'h64, 8'h02);
    bus_write(8'h68, 8'h02);
    check("R6 pull-up", {pad_pu[1], pad_pd[1]}, 24'h2);
    bus_write(8'h68, 8'h00);
    check("R6 pull-down", {pad_pu[1], pad_pd[1]}, 24'h1);
    bus_write(8'h64, 8'h00);
    bus_write(8'h68, 8'h02);
    check("R6 no pull type0", {pad_pu[1], pad_pd[1]}, 24'h0);

    // R7: synchronized state readback
    pad_in = 24'h5A00C3;
    bus_read("R7 first edge old", 8'h10, 8'h00);
    @(negedge clk);
    bus_read("R7 byte0 new", 8'h10, 8'hC3);
    bus_read("R7 byte2 new", 8'h12, 8'h5A);
    ext_lo_en = 1'b0;
    bus_read("R8 state masked", 8'h12, 8'h50);
    ext_lo_en = 1'b1;

    // R9: read and write in the same cycle
    bus_addr = 8'h61; bus_wdata = 8'h3C; bus_wr = 1'b1; bus_rd = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; bus_rd = 1'b0;
    check("R9 pre-write value", {16'h0, bus_rdata}, 24'h000080);
    bus_read("R9 new value", 8'h61, 8'h3C);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule